// File: doc/BRIEF.md
# ACPI I/O Decode and SCI Router

This block is a small configuration-register unit inside a legacy I/O bridge. It holds two registers that software programs through a simple configuration port: a 32-bit power-management base register, which places a 128-byte I/O window anywhere in the 64 KB I/O space on a 128-byte boundary, and an 8-bit ACPI control register. The control register carries a decode enable and a 3-bit interrupt select.

Every I/O cycle address on the bridge is compared against the programmed window. A window hit is raised only while decode is enabled. A second hit output flags the two fixed APM ports, and that output does not depend on the enable. The internal SCI request is steered onto one of seven interrupt outputs. Four of those outputs may only be used while the APIC is enabled. Hits and routing are combinational, so the bridge can claim a cycle in the same clock in which the address is presented.

Top module: `acpi_io_decode_top`

## Requirements
- R1: After reset, a read at offset 40h returns 00000001h and a read at offset 44h returns 00000000h.
- R2: In the base register, bits 15:7 are read/write and hold the window base. Bit 0 always reads 1. Bits 31:16 and 6:1 always read 0, and writes to them are dropped.
- R3: A write updates only the bytes whose enable is set, where `cfg_be[n]` covers data bits 8n+7:8n. A write with all enables clear changes nothing.
- R4: In the control register at offset 44h, bit 4 is the decode enable and bits 2:0 are the SCI select. Bits 7:5 and 3 read 0 and are not stored.
- R5: `win_hit` is 1 exactly when the decode enable is 1 and `io_addr[15:7]` equals the base field.
- R6: `apm_hit` is 1 exactly when `io_addr` is 00B2h or 00B3h, whatever the decode enable.
- R7: While `sci_req` is 1, select code 0, 1 and 2 drive `sci_irq` bit 0, 1 and 2 (IRQ9, IRQ10, IRQ11). Codes 4 to 7 drive bits 3 to 6 (IRQ20 to IRQ23). While `sci_req` is 0, all bits are 0.
- R8: Code 3 drives no output. Codes 4 to 7 drive no output while `apic_en` is 0.
- R9: At most one bit of `sci_irq` is 1 at any time.
- R10: A register write takes effect from the next clock. Registers are selected by `cfg_addr[7:2]`, and the two low address bits are ignored. Any offset other than the 40h and 44h dwords reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (dword selected by bits 7:2) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| io_addr | input | 16 | Address of the current I/O cycle |
| apic_en | input | 1 | APIC enabled, which allows the high interrupt codes |
| sci_req | input | 1 | Internal SCI request |
| win_hit | output | 1 | I/O address falls in the enabled 128-byte window |
| apm_hit | output | 1 | I/O address is one of the APM ports |
| sci_irq | output | 7 | Steered SCI: IRQ9, IRQ10, IRQ11, IRQ20 to IRQ23 in bits 0 to 6 |

## Verification
The assertions take for granted that `cfg_wr`, `cfg_be` and `cfg_wdata` are settled before the clock edge, and that the register values they check were set by writes at least one clock earlier. They also assume `apic_en` and `sci_req` are plain levels with no meaning tied to history. The stimulus changes inputs only on the falling edge and lets a write strobe last exactly one clock. Random I/O addresses are pulled half the time into the programmed window, and just outside it, so that hits and near misses both occur. The select code and the APIC enable are drawn across their full range, so the reserved code and the APIC-only codes are hit in both APIC states.

// File: rtl/acpi_dec_pkg.sv
package acpi_dec_pkg;

    localparam int IO_AW   = 16;
    localparam int WIN_LG  = 7;
    localparam int BASE_W  = IO_AW - WIN_LG;
    localparam int CFG_AW  = 8;
    localparam int DW      = 32;
    localparam int BE_W    = DW / 8;
    localparam int SEL_W   = 3;
    localparam int NIRQ    = 7;
    localparam int EN_BIT  = 4;

    localparam logic [CFG_AW-1:0] OFS_BASE = 8'h40;
    localparam logic [CFG_AW-1:0] OFS_CTRL = 8'h44;
    localparam logic [IO_AW-1:0]  APM_CMD  = 16'h00B2;
    localparam logic [IO_AW-1:0]  APM_STS  = 16'h00B3;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_BASE,
        RSEL_CTRL
    } rsel_e;

    function automatic rsel_e decode_ofs(input logic [CFG_AW-1:0] a);
        if (a[CFG_AW-1:2] == OFS_BASE[CFG_AW-1:2])      return RSEL_BASE;
        else if (a[CFG_AW-1:2] == OFS_CTRL[CFG_AW-1:2]) return RSEL_CTRL;
        else                                            return RSEL_NONE;
    endfunction

    function automatic logic [DW-1:0] base_image(input logic [BASE_W-1:0] b);
        logic [DW-1:0] v;
        v = '0;
        v[IO_AW-1:WIN_LG] = b;
        v[0] = 1'b1;
        return v;
    endfunction

    function automatic logic [DW-1:0] ctrl_image(input ctrl_t c);
        logic [DW-1:0] v;
        v = '0;
        v[EN_BIT] = c.en;
        v[SEL_W-1:0] = c.sel;
        return v;
    endfunction

    // select code -> output index; valid=0 leaves all outputs low
    function automatic logic [NIRQ-1:0] sci_route(input logic [SEL_W-1:0] sel,
                                                  input logic apic,
                                                  input logic req);
        logic [NIRQ-1:0] v;
        v = '0;
        if (req) begin
            if (!sel[SEL_W-1]) begin
                if (sel != 3'd3) v[sel[1:0]] = 1'b1;
            end else if (apic) begin
                v[3 + int'(sel[1:0])] = 1'b1;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import acpi_dec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [CFG_AW-1:0]   addr,
    input  logic [BE_W-1:0]     be,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic [BASE_W-1:0]   base_q,
    output ctrl_t               ctrl_q
);
    rsel_e         rsel;
    logic [DW-1:0] base_cur;
    logic [DW-1:0] base_mrg;
    logic [DW-1:0] ctrl_cur;
    logic [DW-1:0] ctrl_mrg;

    assign rsel     = decode_ofs(addr);
    assign base_cur = base_image(base_q);
    assign ctrl_cur = ctrl_image(ctrl_q);

    for (genvar b = 0; b < BE_W; b++) begin : g_byte
        assign base_mrg[8*b +: 8] = be[b] ? wdata[8*b +: 8] : base_cur[8*b +: 8];
        assign ctrl_mrg[8*b +: 8] = be[b] ? wdata[8*b +: 8] : ctrl_cur[8*b +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ctrl_q <= '0;
        end else if (wr) begin
            if (rsel == RSEL_BASE) base_q <= base_mrg[IO_AW-1:WIN_LG];
            if (rsel == RSEL_CTRL) begin
                ctrl_q.en  <= ctrl_mrg[EN_BIT];
                ctrl_q.sel <= ctrl_mrg[SEL_W-1:0];
            end
        end
    end

    always_comb begin
        case (rsel)
            RSEL_BASE: rdata = base_cur;
            RSEL_CTRL: rdata = ctrl_cur;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/io_window_decode.sv
module io_window_decode
    import acpi_dec_pkg::*;
(
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [BASE_W-1:0] base,
    input  logic              en,
    output logic              win_hit,
    output logic              apm_hit
);
    assign win_hit = en && (io_addr[IO_AW-1:WIN_LG] == base);
    assign apm_hit = (io_addr == APM_CMD) || (io_addr == APM_STS);
endmodule

// File: rtl/sci_steer.sv
module sci_steer
    import acpi_dec_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             apic_en,
    input  logic             req,
    output logic [NIRQ-1:0]  irq
);
    assign irq = sci_route(sel, apic_en, req);
endmodule

// File: rtl/acpi_io_decode_top.sv
module acpi_io_decode_top
    import acpi_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [15:0]       io_addr,
    input  logic              apic_en,
    input  logic              sci_req,
    output logic              win_hit,
    output logic              apm_hit,
    output logic [6:0]        sci_irq
);
    logic [BASE_W-1:0] base_q;
    ctrl_t             ctrl_q;

    pm_cfg_regs i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .addr   (cfg_addr),
        .be     (cfg_be),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .base_q (base_q),
        .ctrl_q (ctrl_q)
    );

    io_window_decode i_dec (
        .io_addr (io_addr),
        .base    (base_q),
        .en      (ctrl_q.en),
        .win_hit (win_hit),
        .apm_hit (apm_hit)
    );

    sci_steer i_sci (
        .sel     (ctrl_q.sel),
        .apic_en (apic_en),
        .req     (sci_req),
        .irq     (sci_irq)
    );

endmodule

// File: rtl/acpi_io_decode_chk.sv
module acpi_io_decode_chk
    import acpi_dec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic [7:0]        cfg_addr,
    input logic [3:0]        cfg_be,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       cfg_rdata,
    input logic              apic_en,
    input logic              sci_req,
    input logic              win_hit,
    input logic [6:0]        sci_irq,
    input logic [BASE_W-1:0] base_q,
    input ctrl_t             ctrl_q
);
    // R9
    sci_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sci_irq));

    // R7
    sci_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (sci_irq != '0) |-> sci_req);

    // R8
    sci_apic_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !apic_en |-> (sci_irq[6:3] == '0));

    // R2
    base_fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr[7:2] == 6'h10) |-> (cfg_rdata[0] && cfg_rdata[31:16] == '0 && cfg_rdata[6:1] == '0));

    // R3
    no_be_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_be == '0) |=> ($stable(base_q) && $stable(ctrl_q)));

    // R5
    disable_kills_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr[7:2] == 6'h11 && cfg_be[0] && !cfg_wdata[4]) |=> !win_hit);

    // R10
    other_ofs_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr[7:2] != 6'h10 && cfg_addr[7:2] != 6'h11) |=> ($stable(base_q) && $stable(ctrl_q)));
endmodule

bind acpi_io_decode_top acpi_io_decode_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .apic_en   (apic_en),
    .sci_req   (sci_req),
    .win_hit   (win_hit),
    .sci_irq   (sci_irq),
    .base_q    (base_q),
    .ctrl_q    (ctrl_q)
);

// File: tb/test_acpi_io_decode_top.sv
module test_acpi_io_decode_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [7:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [15:0] io_addr;
    logic        apic_en;
    logic        sci_req;
    logic        win_hit;
    logic        apm_hit;
    logic [6:0]  sci_irq;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the register contents
    logic [8:0] m_base;
    logic       m_en;
    logic [2:0] m_sel;

    always #10 clk = ~clk;

    acpi_io_decode_top i_acpi_io_decode_top (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
        .apic_en(apic_en), .sci_req(sci_req), .win_hit(win_hit), .apm_hit(apm_hit),
        .sci_irq(sci_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a[7:2] == 6'h10) return {16'h0, m_base, 6'b0, 1'b1};
        if (a[7:2] == 6'h11) return {24'h0, 3'b0, m_en, 1'b0, m_sel};
        return 32'h0;
    endfunction

    function automatic logic exp_win(input logic [15:0] a);
        return m_en && (a[15:7] == m_base);
    endfunction

    function automatic logic exp_apm(input logic [15:0] a);
        return (a == 16'h00B2) || (a == 16'h00B3);
    endfunction

    function automatic logic [6:0] exp_irq(input logic [2:0] s, input logic ap, input logic rq);
        logic [6:0] v;
        v = '0;
        if (rq) begin
            case (s)
                3'd0: v[0] = 1'b1;
                3'd1: v[1] = 1'b1;
                3'd2: v[2] = 1'b1;
                3'd3: v = '0;
                default: if (ap) v[int'(s) - 1] = 1'b1;
            endcase
        end
        return v;
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        if (a[7:2] == 6'h10) return "R2";
        if (a[7:2] == 6'h11) return "R4";
        return "R10";
    endfunction

    // one-clock write; model updated when the design registers it (R10)
    task automatic do_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] img;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
        if (a[7:2] == 6'h10) begin
            img = exp_rd(a);
            for (int b = 0; b < 4; b++) if (be[b]) img[8*b +: 8] = d[8*b +: 8];
            m_base = img[15:7];
        end else if (a[7:2] == 6'h11 && be[0]) begin
            m_en  = d[4];
            m_sel = d[2:0];
        end
    endtask

    task automatic check_all(input logic [7:0] ra, input logic [15:0] ia, input logic ap, input logic rq);
        cfg_addr = ra; io_addr = ia; apic_en = ap; sci_req = rq;
        #2;
        chk(cfg_rdata === exp_rd(ra), rd_tag(ra), cfg_rdata, exp_rd(ra));
        chk(win_hit === exp_win(ia), "R5", {31'b0, win_hit}, {31'b0, exp_win(ia)});
        chk(apm_hit === exp_apm(ia), "R6", {31'b0, apm_hit}, {31'b0, exp_apm(ia)});
        chk(sci_irq === exp_irq(m_sel, ap, rq), "R7", {25'b0, sci_irq}, {25'b0, exp_irq(m_sel, ap, rq)});
        chk($countones(sci_irq) <= 1, "R9", {25'b0, sci_irq}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        logic [7:0]  ra;
        logic [15:0] ia;
        seed = $urandom(32'd1234);
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = 8'h40; cfg_be = '0; cfg_wdata = '0;
        io_addr = '0; apic_en = 1'b0; sci_req = 1'b0;
        m_base = '0; m_en = 1'b0; m_sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        cfg_addr = 8'h40; #2;
        chk(cfg_rdata === 32'h0000_0001, "R1", cfg_rdata, 32'h0000_0001);
        cfg_addr = 8'h44; #2;
        chk(cfg_rdata === 32'h0, "R1", cfg_rdata, 32'h0);
        check_all(8'h40, 16'h0000, 1'b0, 1'b0);

        // R2: reserved base bits dropped, bit0 forced
        do_wr(8'h40, 4'hF, 32'hFFFF_FFFE);
        cfg_addr = 8'h40; #2;
        chk(cfg_rdata === 32'h0000_FF81, "R2", cfg_rdata, 32'h0000_FF81);

        // R3: only byte 1 written, bit 7 retained
        do_wr(8'h40, 4'b0010, 32'hAAAA_12AA);
        cfg_addr = 8'h41; #2;
        chk(cfg_rdata === 32'h0000_1281, "R3", cfg_rdata, 32'h0000_1281);

        // R4: reserved control bits read 0
        do_wr(8'h44, 4'b0001, 32'h0000_00FF);
        cfg_addr = 8'h44; #2;
        chk(cfg_rdata === 32'h0000_0017, "R4", cfg_rdata, 32'h0000_0017);

        // R5: window edges
        check_all(8'h44, 16'h1280, 1'b1, 1'b1);
        check_all(8'h44, 16'h12FF, 1'b1, 1'b1);
        check_all(8'h44, 16'h1300, 1'b1, 1'b1);
        check_all(8'h44, 16'h127F, 1'b1, 1'b1);

        // R6: APM ports decoded with enable cleared
        do_wr(8'h44, 4'b0001, 32'h0000_0005);
        check_all(8'h44, 16'h1280, 1'b0, 1'b1);
        io_addr = 16'h00B3; #2;
        chk(apm_hit === 1'b1, "R6", {31'b0, apm_hit}, 32'h1);
        io_addr = 16'h00B2; #2;
        chk(apm_hit === 1'b1, "R6", {31'b0, apm_hit}, 32'h1);

        // R8: APIC-only code with APIC off, then on; reserved code
        sci_req = 1'b1; apic_en = 1'b0; #2;
        chk(sci_irq === 7'h0, "R8", {25'b0, sci_irq}, 32'h0);
        apic_en = 1'b1; #2;
        chk(sci_irq === 7'b001_0000, "R7", {25'b0, sci_irq}, 32'h10);
        do_wr(8'h44, 4'b0001, 32'h0000_0003);
        check_all(8'h44, 16'h0000, 1'b1, 1'b1);
        chk(sci_irq === 7'h0, "R8", {25'b0, sci_irq}, 32'h0);

        // R3: no enables -> no change; R10: other offset ignored
        do_wr(8'h44, 4'b0000, 32'h0000_0011);
        do_wr(8'h48, 4'hF, 32'hFFFF_FFFF);
        check_all(8'h44, 16'h0000, 1'b0, 1'b0);
        check_all(8'h48, 16'h0000, 1'b0, 1'b0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 1) == 1) begin
                case ($urandom_range(0, 3))
                    0: ra = 8'h40 | 8'($urandom_range(0, 3));
                    1: ra = 8'h44 | 8'($urandom_range(0, 3));
                    2: ra = 8'h48;
                    default: ra = 8'($urandom);
                endcase
                do_wr(ra, 4'($urandom), $urandom);
            end
            if ($urandom_range(0, 1) == 1)
                ia = {m_base, 7'($urandom)} + 16'($urandom_range(0, 2)) - 16'd1;
            else if ($urandom_range(0, 7) == 0)
                ia = 16'h00B2 + 16'($urandom_range(0, 2));
            else
                ia = 16'($urandom);
            ra = ($urandom_range(0, 2) == 0) ? 8'($urandom) : (8'h40 + 8'($urandom_range(0, 7)));
            @(negedge clk);
            check_all(ra, ia, 1'($urandom), 1'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule